// File: doc/BRIEF.md
# XOR Interleave Position Restorer

When host bridges pick their interleave target through an XOR hash of address bits, the host offset that a plain modulo translation produces has the wrong value in a few low position bits. This block takes that modulo offset and fixes it. It runs a fixed chain of bit masks. Each step takes the parity of the offset bits that its mask selects and writes that parity into the bit where the mask's lowest one sits. The next step works on the result of the previous one.

The host-bridge way encoding sets how many masks of the chain take part. Encodings for one and three ways use no mask. Two and six ways use the first mask. Four and twelve ways use the first two. Eight ways uses three and sixteen ways uses all four. Any other encoding gives an all-ones offset with an error flag. A single output register holds the result behind a valid/ready handshake.

Top module: `xor_pos_restore`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: An input is accepted on a clock edge where `in_valid` and `in_ready` are both 1. `in_ready` equals `!out_valid || out_ready`. The result shows on `out_valid`/`out_offset` after that edge. The result stays unchanged while `out_valid` is 1 and `out_ready` is 0.
- R3: A step with mask M replaces the offset bit at M's lowest set bit with the XOR of all bits of (offset AND M). Steps run in order 0,1,2,3, and each step uses the previous step's output.
- R4: Way codes 0 (1-way) and 8 (3-way) pass the offset through unchanged.
- R5: Way codes 1 (2-way) and 9 (6-way) apply step 0 only. The default mask is 0x2020900.
- R6: Way codes 2 (4-way) and 10 (12-way) apply steps 0 and 1. Step 1 defaults to 0x4041200. With code 2, 272 stays 272. With code 10, the offsets 2048 and 2304 trade places.
- R7: Way code 3 (8-way) applies steps 0–2, where step 2 defaults to 0x1010400. Way code 4 (16-way) applies steps 0–3, where step 3 defaults to 0x800.
- R8: Any other way code gives `out_offset` of all ones with `out_err` 1. Supported codes give `out_err` 0.
- R9: A step whose mask parameter is zero leaves the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input offered |
| in_ready | output | 1 | Input can be accepted |
| in_offset | input | ADDR_W | Modulo-translated host offset |
| in_ways | input | 4 | Host-bridge way encoding |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Result consumed |
| out_offset | output | ADDR_W | Restored host offset |
| out_err | output | 1 | Unsupported way encoding |

## Verification
The bench builds two instances on shared inputs. The first, u0, uses ADDR_W=52 and the default masks, so the published 4-way and 12-way sample offsets and the full four-step 16-way chain can all be exercised. The second, u1, sets the step-1 mask to zero. With it, a four-way encoding must give the same result as the first step alone, which puts the zero-mask bypass within reach. Random offsets across all sixteen encodings cover both the unsupported codes and back-pressure stalls.

// File: rtl/xor_pos_restore.sv
module xor_pos_restore #(
  parameter int ADDR_W = 52,
  parameter logic [ADDR_W-1:0] MASK0 = ADDR_W'(64'h2020900),
  parameter logic [ADDR_W-1:0] MASK1 = ADDR_W'(64'h4041200),
  parameter logic [ADDR_W-1:0] MASK2 = ADDR_W'(64'h1010400),
  parameter logic [ADDR_W-1:0] MASK3 = ADDR_W'(64'h800)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_offset,
  input  logic [3:0]        in_ways,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_offset,
  output logic              out_err
);
  localparam int NSTEP = 4;
  localparam logic [NSTEP-1:0][ADDR_W-1:0] MASKS = {MASK3, MASK2, MASK1, MASK0};

  function automatic int low_bit(input logic [ADDR_W-1:0] m);
    int r = 0;
    for (int i = ADDR_W - 1; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  logic [2:0] nsteps;
  logic       bad;
  logic [ADDR_W-1:0] stage [NSTEP+1];

  always_comb begin
    bad = 1'b0;
    case (in_ways)
      4'd0, 4'd8:  nsteps = 3'd0;
      4'd1, 4'd9:  nsteps = 3'd1;
      4'd2, 4'd10: nsteps = 3'd2;
      4'd3:        nsteps = 3'd3;
      4'd4:        nsteps = 3'd4;
      default: begin nsteps = 3'd0; bad = 1'b1; end
    endcase
  end

  assign stage[0] = in_offset;

  for (genvar k = 0; k < NSTEP; k++) begin : g_step
    if (MASKS[k] == '0) begin : g_skip
      assign stage[k+1] = stage[k];
    end else begin : g_hash
      localparam int LSB = low_bit(MASKS[k]);
      logic par;
      assign par = ^(stage[k] & MASKS[k]);
      assign stage[k+1] = (nsteps > 3'(k))
        ? ((stage[k] & ~(ADDR_W'(1) << LSB)) | (ADDR_W'(par) << LSB))
        : stage[k];
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_offset <= '0;
      out_err    <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid  <= 1'b1;
      out_offset <= bad ? '1 : stage[NSTEP];
      out_err    <= bad;
    end else if (out_ready) begin
      out_valid  <= 1'b0;
    end
  end
endmodule

module xor_pos_restore_chk #(parameter int ADDR_W = 52) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [ADDR_W-1:0] in_offset,
  input logic [3:0]        in_ways,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_offset,
  input logic              out_err
);
  // R2
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_offset) && $stable(out_err));
  // R2
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  // R1
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
  // R4
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && (in_ways == 4'd0 || in_ways == 4'd8)
    |=> out_offset == $past(in_offset) && !out_err);
  // R8
  err_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> &out_offset);
endmodule

bind xor_pos_restore xor_pos_restore_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_xor_pos_restore.sv
module sim_xor_pos_restore;
  localparam int W = 52;
  logic clk = 0, rst_n = 0, in_valid = 0, out_ready = 1;
  logic [W-1:0] in_offset = '0;
  logic [3:0] in_ways = '0;
  logic in_ready, out_valid, out_err, in_ready1, out_valid1, out_err1;
  logic [W-1:0] out_offset, out_offset1;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  xor_pos_restore #(.ADDR_W(W)) u0 (.clk, .rst_n, .in_valid, .in_ready, .in_offset,
    .in_ways, .out_valid, .out_ready, .out_offset, .out_err);
  xor_pos_restore #(.ADDR_W(W), .MASK1('0)) u1 (.clk, .rst_n, .in_valid, .in_ready(in_ready1),
    .in_offset, .in_ways, .out_valid(out_valid1), .out_ready, .out_offset(out_offset1),
    .out_err(out_err1));

  function automatic logic [W-1:0] step(input logic [W-1:0] v, input logic [W-1:0] m);
    int lo = -1;
    logic p = 0;
    if (m == 0) return v;
    for (int i = 0; i < W; i++) begin
      if (m[i]) p ^= v[i];
      if (m[i] && lo < 0) lo = i;
    end
    v[lo] = p;
    return v;
  endfunction

  function automatic int nsteps(input logic [3:0] c);
    case (c)
      0, 8: return 0;
      1, 9: return 1;
      2, 10: return 2;
      3: return 3;
      4: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic logic [W-1:0] model(input logic [W-1:0] v, input logic [3:0] c, input bit zero1);
    logic [W-1:0] m [4];
    int n = nsteps(c);
    m[0] = W'(64'h2020900); m[1] = zero1 ? '0 : W'(64'h4041200);
    m[2] = W'(64'h1010400); m[3] = W'(64'h800);
    if (n < 0) return '1;
    for (int k = 0; k < n; k++) v = step(v, m[k]);
    return v;
  endfunction

  task automatic chk(input string r, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic xact(input logic [W-1:0] v, input logic [3:0] c, input string r);
    @(negedge clk);
    in_valid = 1; in_offset = v; in_ways = c;
    @(negedge clk);
    in_valid = 0;
    chk(r, W'(out_valid), W'(1));
    chk(r, out_offset, model(v, c, 0));
    chk(r, W'(out_err), W'(nsteps(c) < 0));
    chk(r, out_offset1, model(v, c, 1));
  endtask

  initial begin
    #100000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    chk("R1", W'(out_valid), W'(0));
    chk("R1", W'(in_ready), W'(1));
    rst_n = 1;
    xact(W'(272), 4'd2, "R6");
    chk("R6", out_offset, W'(272));
    xact(W'(1056), 4'd2, "R6");
    chk("R6", out_offset, W'(1056));
    xact(W'(2048), 4'd10, "R6");
    chk("R6", out_offset, W'(2304));
    xact(W'(2304), 4'd10, "R6");
    chk("R6", out_offset, W'(2048));
    xact(W'(2048), 4'd1, "R5");
    chk("R5", out_offset, W'(2304));
    xact(W'(64'h123456789), 4'd0, "R4");
    xact(W'(64'h123456789), 4'd8, "R4");
    chk("R4", out_offset, W'(64'h123456789));
    xact(W'(64'h1010000), 4'd3, "R7");
    chk("R7", out_offset, W'(64'h1010000));
    xact(W'(64'h10000), 4'd3, "R7");
    chk("R7", out_offset, W'(64'h10400));
    xact(W'(64'hFFFFFFF), 4'd4, "R3");
    xact(W'(5), 4'd7, "R8");
    chk("R8", out_offset, '1);
    xact(W'(64'h40000), 4'd2, "R9");
    chk("R9", out_offset1, W'(64'h40000));
    // R2 stall
    @(negedge clk);
    out_ready = 0; in_valid = 1; in_offset = W'(2048); in_ways = 4'd10;
    @(negedge clk);
    in_offset = W'(64'h999); in_ways = 4'd0;
    chk("R2", W'(in_ready), W'(0));
    @(negedge clk);
    chk("R2", out_offset, W'(2304));
    chk("R2", W'(out_valid), W'(1));
    out_ready = 1;
    @(negedge clk);
    in_valid = 0;
    chk("R2", out_offset, W'(64'h999));
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] v;
      v = W'({$urandom, $urandom});
      xact(v, 4'($urandom), "R3");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule